// File: doc/BRIEF.md
# Dual-Issue Hazard Stall Controller

This block is the interlock decision logic for a two-slot, in-order pipeline with the stages IF/DR, DR/E, E/DF and DF/W. It is purely combinational. Every cycle it looks at the decoded instruction class, the source and destination register numbers, the write enables and the valid bits that sit in the pipeline registers. From these it decides one of three actions: hold the whole fetch bundle, hold only the younger slot, or throw away fetched instructions that sit behind a taken jump.

Slot 0 is the older instruction of a bundle. Holding slot 0 also holds slot 1. Holding slot 1 alone lets slot 0 proceed and nullifies slot 1 for one cycle. Three things drive the rules:
- A multiplier whose result appears three cycles after issue.
- A single shared load/store pipe.
- Predicate-writing instructions whose results a following jump or predicate-set change cannot see in time.

Jumps are treated as not taken. Whether a jump was really taken is resolved outside this block and reported back as an input.

Top module: `hazard_stall_ctrl`

## Requirements
- R1: Class codes are 4 bits: NOP=0, ALU=1, PMUL=2, LDI=3, LD=4, ST=5, STU=6, CMP=7, CHPR=8, JMP=9, JMPR=10.
  - The reader classes are ALU, PMUL, LD, ST, STU, CMP and JMPR.
  - A producer match needs all of these: the producer's write enable is set, its destination is not register 0, and the consumer has the use bit set for a source equal to that destination.
  - In this requirement, both IF/DR slots are valid, slot 0 is ALU, PMUL, LDI, LD or STU, slot 0 is a matching producer for slot 1, and slot 1 is a reader. Then slot 1 is stalled.
- R2: When both IF/DR slots are valid and both hold LD, ST or STU, slot 1 is stalled.
- R3: When both IF/DR slots are valid, slot 1 is stalled in either of two cases. The first is slot 0 being CMP or CHPR while slot 1 is JMP, JMPR or CHPR. The second is slot 0 being CHPR, whatever slot 1 holds.
- R4: Take a valid PMUL or LD in either DR/E slot that is a matching producer for a valid reader in IF/DR slot k. It stalls slot k.
- R5: A valid CMP or CHPR in either DR/E slot stalls a valid CHPR in IF/DR slot k.
- R6: A valid PMUL in either E/DF slot that is a matching producer for a valid reader in IF/DR slot k stalls slot k.
- R7: A valid PMUL in either E/DF slot stalls IF/DR slot 0 in one case: slot 0 is valid, has its write enable set and is not PMUL. It never applies this rule to slot 1.
- R8: A valid JMP or JMPR in IF/DR slot 0 with its taken input set raises cancel_ifdr1_o. This holds unless slot 0 itself is stalled. While cancel_ifdr1_o is high, stall_slot1_o is low.
- R9: A valid JMP or JMPR with its taken bit set in either DR/E slot raises cancel_ifdr_o. This forces stall_slot0_o, stall_slot1_o and cancel_ifdr1_o low.
- R10: A stall of slot 0 forces stall_slot1_o low. Entries whose valid bit is clear take part in no rule, so with no valid entries all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifdr_valid_i | input | 2 | IF/DR slot valid bits |
| ifdr_cls_i | input | 2x4 | IF/DR slot class codes |
| ifdr_src_a_i | input | 2x5 | IF/DR first source register |
| ifdr_src_b_i | input | 2x5 | IF/DR second source register |
| ifdr_use_a_i | input | 2 | First source is read |
| ifdr_use_b_i | input | 2 | Second source is read |
| ifdr0_dst_i | input | 5 | IF/DR slot 0 destination |
| ifdr0_we_i | input | 1 | IF/DR slot 0 writes the register file |
| ifdr0_taken_i | input | 1 | IF/DR slot 0 jump resolved taken |
| drex_valid_i | input | 2 | DR/E slot valid bits |
| drex_cls_i | input | 2x4 | DR/E class codes |
| drex_dst_i | input | 2x5 | DR/E destinations |
| drex_we_i | input | 2 | DR/E write enables |
| drex_taken_i | input | 2 | DR/E jump resolved taken |
| edf_valid_i | input | 2 | E/DF slot valid bits |
| edf_cls_i | input | 2x4 | E/DF class codes |
| edf_dst_i | input | 2x5 | E/DF destinations |
| edf_we_i | input | 2 | E/DF write enables |
| stall_slot0_o | output | 1 | Hold the whole IF/DR bundle |
| stall_slot1_o | output | 1 | Hold IF/DR slot 1 only |
| cancel_ifdr1_o | output | 1 | Nullify IF/DR slot 1 |
| cancel_ifdr_o | output | 1 | Nullify both IF/DR slots |

## Verification
The bench targets the producer qualifiers:
- A design that ignored the write enable or the register-0 exclusion would stall on false dependencies.
- A design that skipped the reader-class gate would stall a plain jump that carries register fields.

It drives the write-port collision with a PMUL in IF/DR slot 0, and again with the writer in slot 1 only. A design that applied the rule too broadly would hold bundles that can safely go.

It stacks hazards onto cancel cases. A design with the wrong override order would stall behind a discarded jump, or cancel slot 1 while the jump is itself held.

// File: rtl/hsc_pkg.sv
// Shared definitions for the hazard stall controller: slot count,
// register address width, instruction class codes and class predicates.
package hsc_pkg;

    localparam int NSLOT = 2;
    localparam int CLS_W = 4;

    typedef enum logic [CLS_W-1:0] {
        CLS_NOP  = 4'd0,
        CLS_ALU  = 4'd1,
        CLS_PMUL = 4'd2,
        CLS_LDI  = 4'd3,
        CLS_LD   = 4'd4,
        CLS_ST   = 4'd5,
        CLS_STU  = 4'd6,
        CLS_CMP  = 4'd7,
        CLS_CHPR = 4'd8,
        CLS_JMP  = 4'd9,
        CLS_JMPR = 4'd10
    } icls_e;

    // Classes whose register sources are checked for dependencies
    function automatic logic cls_reads(input logic [CLS_W-1:0] c);
        return (c == CLS_ALU) || (c == CLS_PMUL) || (c == CLS_LD) ||
               (c == CLS_ST) || (c == CLS_STU) || (c == CLS_CMP) ||
               (c == CLS_JMPR);
    endfunction

    // Classes using the single load/store pipe
    function automatic logic cls_mem(input logic [CLS_W-1:0] c);
        return (c == CLS_LD) || (c == CLS_ST) || (c == CLS_STU);
    endfunction

    // Slot 0 classes whose result slot 1 of the same bundle cannot see
    function automatic logic cls_bundle_prod(input logic [CLS_W-1:0] c);
        return (c == CLS_ALU) || (c == CLS_PMUL) || (c == CLS_LDI) ||
               (c == CLS_LD) || (c == CLS_STU);
    endfunction

    // Multi-cycle producers seen from DR/E
    function automatic logic cls_long(input logic [CLS_W-1:0] c);
        return (c == CLS_PMUL) || (c == CLS_LD);
    endfunction

    // Predicate writers
    function automatic logic cls_predw(input logic [CLS_W-1:0] c);
        return (c == CLS_CMP) || (c == CLS_CHPR);
    endfunction

    // Control transfers
    function automatic logic cls_jump(input logic [CLS_W-1:0] c);
        return (c == CLS_JMP) || (c == CLS_JMPR);
    endfunction

endpackage

// File: rtl/hsc_dep_match.sv
// Read-after-write match of one consumer against one producer.
// Assumes: register 0 is hard-wired, so a write to it never creates a
// dependency; a source counts only when its use bit is set.
module hsc_dep_match #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src_a,
    input  logic [AW-1:0] src_b,
    input  logic          use_a,
    input  logic          use_b,
    input  logic [AW-1:0] dst,
    input  logic          dst_we,
    output logic          hit
);

    logic dst_live;

    // Producer writes a real register
    always_comb dst_live = dst_we && (dst != '0);

    // Any used source equals the producer destination
    always_comb hit = dst_live && ((use_a && (src_a == dst)) ||
                                   (use_b && (src_b == dst)));

endmodule

// File: rtl/hsc_bundle_hazard.sv
// Hazards between the two slots of the bundle held in IF/DR.
// Assumes: slot 0 is older; any hazard found here stalls slot 1 only.
module hsc_bundle_hazard
    import hsc_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic             s0_valid,
    input  logic [CLS_W-1:0] s0_cls,
    input  logic [AW-1:0]    s0_dst,
    input  logic             s0_we,
    input  logic             s1_valid,
    input  logic [CLS_W-1:0] s1_cls,
    input  logic [AW-1:0]    s1_src_a,
    input  logic [AW-1:0]    s1_src_b,
    input  logic             s1_use_a,
    input  logic             s1_use_b,
    output logic             hz_s1
);

    logic raw_hit;
    logic raw_hz, mem_hz, pred_hz, chpr_hz;

    hsc_dep_match #(.AW(AW)) u_raw (
        .src_a  (s1_src_a),
        .src_b  (s1_src_b),
        .use_a  (s1_use_a),
        .use_b  (s1_use_b),
        .dst    (s0_dst),
        .dst_we (s0_we),
        .hit    (raw_hit)
    );

    // Classify the four intra-bundle conflicts
    always_comb begin
        raw_hz  = raw_hit && cls_bundle_prod(s0_cls) && cls_reads(s1_cls);
        mem_hz  = cls_mem(s0_cls) && cls_mem(s1_cls);
        pred_hz = cls_predw(s0_cls) &&
                  (cls_jump(s1_cls) || (s1_cls == CLS_CHPR));
        chpr_hz = (s0_cls == CLS_CHPR);
    end

    // Only a full bundle can conflict with itself
    always_comb hz_s1 = s0_valid && s1_valid &&
                        (raw_hz || mem_hz || pred_hz || chpr_hz);

endmodule

// File: rtl/hsc_slot_hazard.sv
// Hazards of one IF/DR slot against the older instructions in DR/E and E/DF.
// Assumes: DR/E and E/DF each hold NSLOT entries; the write-port collision
// term is fed a write enable only for slot 0 (the caller ties it low otherwise).
module hsc_slot_hazard
    import hsc_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic                         valid,
    input  logic [CLS_W-1:0]             cls,
    input  logic [AW-1:0]                src_a,
    input  logic [AW-1:0]                src_b,
    input  logic                         use_a,
    input  logic                         use_b,
    input  logic                         port_we,
    input  logic [NSLOT-1:0]             drex_valid,
    input  logic [NSLOT-1:0][CLS_W-1:0]  drex_cls,
    input  logic [NSLOT-1:0][AW-1:0]     drex_dst,
    input  logic [NSLOT-1:0]             drex_we,
    input  logic [NSLOT-1:0]             edf_valid,
    input  logic [NSLOT-1:0][CLS_W-1:0]  edf_cls,
    input  logic [NSLOT-1:0][AW-1:0]     edf_dst,
    input  logic [NSLOT-1:0]             edf_we,
    output logic                         hz
);

    logic [NSLOT-1:0] drex_hit, edf_hit;
    logic [NSLOT-1:0] drex_raw, drex_pred, edf_raw, edf_port;
    logic             reader;

    // Consumer is a live instruction that reads registers
    always_comb reader = valid && cls_reads(cls);

    for (genvar j = 0; j < NSLOT; j++) begin : g_older
        hsc_dep_match #(.AW(AW)) u_drex (
            .src_a  (src_a),
            .src_b  (src_b),
            .use_a  (use_a),
            .use_b  (use_b),
            .dst    (drex_dst[j]),
            .dst_we (drex_we[j]),
            .hit    (drex_hit[j])
        );

        hsc_dep_match #(.AW(AW)) u_edf (
            .src_a  (src_a),
            .src_b  (src_b),
            .use_a  (use_a),
            .use_b  (use_b),
            .dst    (edf_dst[j]),
            .dst_we (edf_we[j]),
            .hit    (edf_hit[j])
        );

        // Per-older-entry hazard terms
        always_comb begin
            drex_raw[j]  = drex_valid[j] && cls_long(drex_cls[j]) &&
                           drex_hit[j];
            drex_pred[j] = drex_valid[j] && cls_predw(drex_cls[j]) &&
                           valid && (cls == CLS_CHPR);
            edf_raw[j]   = edf_valid[j] && (edf_cls[j] == CLS_PMUL) &&
                           edf_hit[j];
            edf_port[j]  = edf_valid[j] && (edf_cls[j] == CLS_PMUL) &&
                           valid && port_we && (cls != CLS_PMUL);
        end
    end

    // Combine all cross-stage reasons for this slot
    always_comb hz = (reader && (|drex_raw || |edf_raw)) ||
                     |drex_pred || |edf_port;

endmodule

// File: rtl/hazard_stall_ctrl.sv
// Stall and cancel decision for a dual-issue in-order pipeline.
// Assumes: slot 0 is the older instruction; jumps are fetched as not taken
// and their taken status is resolved outside; purely combinational.
module hazard_stall_ctrl
    import hsc_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [NSLOT-1:0]             ifdr_valid_i,
    input  logic [NSLOT-1:0][CLS_W-1:0]  ifdr_cls_i,
    input  logic [NSLOT-1:0][AW-1:0]     ifdr_src_a_i,
    input  logic [NSLOT-1:0][AW-1:0]     ifdr_src_b_i,
    input  logic [NSLOT-1:0]             ifdr_use_a_i,
    input  logic [NSLOT-1:0]             ifdr_use_b_i,
    input  logic [AW-1:0]                ifdr0_dst_i,
    input  logic                         ifdr0_we_i,
    input  logic                         ifdr0_taken_i,
    input  logic [NSLOT-1:0]             drex_valid_i,
    input  logic [NSLOT-1:0][CLS_W-1:0]  drex_cls_i,
    input  logic [NSLOT-1:0][AW-1:0]     drex_dst_i,
    input  logic [NSLOT-1:0]             drex_we_i,
    input  logic [NSLOT-1:0]             drex_taken_i,
    input  logic [NSLOT-1:0]             edf_valid_i,
    input  logic [NSLOT-1:0][CLS_W-1:0]  edf_cls_i,
    input  logic [NSLOT-1:0][AW-1:0]     edf_dst_i,
    input  logic [NSLOT-1:0]             edf_we_i,
    output logic                         stall_slot0_o,
    output logic                         stall_slot1_o,
    output logic                         cancel_ifdr1_o,
    output logic                         cancel_ifdr_o
);

    logic [NSLOT-1:0] slot_hz;
    logic [NSLOT-1:0] drex_jmp;
    logic             bundle_hz;
    logic             hz0, hz1;
    logic             jmp0_taken, jmp_dr_taken, c1;

    hsc_bundle_hazard #(.AW(AW)) u_bundle (
        .s0_valid (ifdr_valid_i[0]),
        .s0_cls   (ifdr_cls_i[0]),
        .s0_dst   (ifdr0_dst_i),
        .s0_we    (ifdr0_we_i),
        .s1_valid (ifdr_valid_i[1]),
        .s1_cls   (ifdr_cls_i[1]),
        .s1_src_a (ifdr_src_a_i[1]),
        .s1_src_b (ifdr_src_b_i[1]),
        .s1_use_a (ifdr_use_a_i[1]),
        .s1_use_b (ifdr_use_b_i[1]),
        .hz_s1    (bundle_hz)
    );

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        logic port_we;

        // Write-port collision applies to the oldest slot only
        if (k == 0) begin : g_port
            always_comb port_we = ifdr0_we_i;
        end else begin : g_noport
            always_comb port_we = 1'b0;
        end

        hsc_slot_hazard #(.AW(AW)) u_slot (
            .valid      (ifdr_valid_i[k]),
            .cls        (ifdr_cls_i[k]),
            .src_a      (ifdr_src_a_i[k]),
            .src_b      (ifdr_src_b_i[k]),
            .use_a      (ifdr_use_a_i[k]),
            .use_b      (ifdr_use_b_i[k]),
            .port_we    (port_we),
            .drex_valid (drex_valid_i),
            .drex_cls   (drex_cls_i),
            .drex_dst   (drex_dst_i),
            .drex_we    (drex_we_i),
            .edf_valid  (edf_valid_i),
            .edf_cls    (edf_cls_i),
            .edf_dst    (edf_dst_i),
            .edf_we     (edf_we_i),
            .hz         (slot_hz[k])
        );

        // Taken jump detection per DR/E entry
        always_comb drex_jmp[k] = drex_valid_i[k] && drex_taken_i[k] &&
                                  cls_jump(drex_cls_i[k]);
    end

    // Raw hazard reasons per slot
    always_comb begin
        hz0 = slot_hz[0];
        hz1 = slot_hz[1] || bundle_hz;
    end

    // Taken jump sources
    always_comb begin
        jmp_dr_taken = |drex_jmp;
        jmp0_taken   = ifdr_valid_i[0] && ifdr0_taken_i &&
                       cls_jump(ifdr_cls_i[0]);
    end

    // Priority: older cancel, then slot 0 stall, then young cancel, then slot 1 stall
    always_comb begin
        c1             = !jmp_dr_taken && jmp0_taken && !hz0;
        cancel_ifdr_o  = jmp_dr_taken;
        cancel_ifdr1_o = c1;
        stall_slot0_o  = !jmp_dr_taken && hz0;
        stall_slot1_o  = !jmp_dr_taken && !hz0 && !c1 && hz1;
    end

endmodule

// File: rtl/hsc_checker.sv
// Output consistency checks for hazard_stall_ctrl, attached by bind.
// Assumes: the controller is combinational, so checks are immediate.
module hsc_checker
    import hsc_pkg::*;
(
    input logic [NSLOT-1:0] ifdr_valid_i,
    input logic [NSLOT-1:0] drex_valid_i,
    input logic             stall_slot0_o,
    input logic             stall_slot1_o,
    input logic             cancel_ifdr1_o,
    input logic             cancel_ifdr_o
);

    // Output relations that must hold in every settled state
    always_comb begin
        p_prio_r10: assert (!(stall_slot0_o && stall_slot1_o))
            else $error("slot0 and slot1 stall together");
        p_cancel_all_r9: assert (!cancel_ifdr_o ||
                                 (!stall_slot0_o && !stall_slot1_o && !cancel_ifdr1_o))
            else $error("bundle cancel not overriding");
        p_cancel_src_r9: assert (!cancel_ifdr_o || (drex_valid_i != '0))
            else $error("bundle cancel without DR/E entry");
        p_cancel1_r8: assert (!cancel_ifdr1_o ||
                              (!stall_slot1_o && !stall_slot0_o && ifdr_valid_i[0]))
            else $error("slot1 cancel inconsistent");
        p_s1_valid_r1: assert (!stall_slot1_o || ifdr_valid_i[1])
            else $error("stall of empty slot1");
        p_idle_r10: assert ((ifdr_valid_i != '0) || (drex_valid_i != '0) ||
                            !(stall_slot0_o || stall_slot1_o ||
                              cancel_ifdr1_o || cancel_ifdr_o))
            else $error("activity with no valid entries");
    end

endmodule

bind hazard_stall_ctrl hsc_checker i_hsc_checker (
    .ifdr_valid_i   (ifdr_valid_i),
    .drex_valid_i   (drex_valid_i),
    .stall_slot0_o  (stall_slot0_o),
    .stall_slot1_o  (stall_slot1_o),
    .cancel_ifdr1_o (cancel_ifdr1_o),
    .cancel_ifdr_o  (cancel_ifdr_o)
);

// File: tb/test_hazard_stall_ctrl.sv
// Directed bench for hazard_stall_ctrl: one task per scenario.
module test_hazard_stall_ctrl;
    import hsc_pkg::*;

    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [1:0]       ifdr_valid, ifdr_use_a, ifdr_use_b;
    logic [1:0][3:0]  ifdr_cls;
    logic [1:0][4:0]  ifdr_src_a, ifdr_src_b;
    logic [4:0]       ifdr0_dst;
    logic             ifdr0_we, ifdr0_taken;
    logic [1:0]       drex_valid, drex_we, drex_taken;
    logic [1:0][3:0]  drex_cls;
    logic [1:0][4:0]  drex_dst;
    logic [1:0]       edf_valid, edf_we;
    logic [1:0][3:0]  edf_cls;
    logic [1:0][4:0]  edf_dst;
    logic             s0, s1, c1, c;

    int n_run = 0;
    int n_fail = 0;

    hazard_stall_ctrl #(.AW(AW)) i_hazard_stall_ctrl (
        .ifdr_valid_i   (ifdr_valid),
        .ifdr_cls_i     (ifdr_cls),
        .ifdr_src_a_i   (ifdr_src_a),
        .ifdr_src_b_i   (ifdr_src_b),
        .ifdr_use_a_i   (ifdr_use_a),
        .ifdr_use_b_i   (ifdr_use_b),
        .ifdr0_dst_i    (ifdr0_dst),
        .ifdr0_we_i     (ifdr0_we),
        .ifdr0_taken_i  (ifdr0_taken),
        .drex_valid_i   (drex_valid),
        .drex_cls_i     (drex_cls),
        .drex_dst_i     (drex_dst),
        .drex_we_i      (drex_we),
        .drex_taken_i   (drex_taken),
        .edf_valid_i    (edf_valid),
        .edf_cls_i      (edf_cls),
        .edf_dst_i      (edf_dst),
        .edf_we_i       (edf_we),
        .stall_slot0_o  (s0),
        .stall_slot1_o  (s1),
        .cancel_ifdr1_o (c1),
        .cancel_ifdr_o  (c)
    );

    task automatic clr();
        ifdr_valid = '0; ifdr_cls = '0; ifdr_src_a = '0; ifdr_src_b = '0;
        ifdr_use_a = '0; ifdr_use_b = '0; ifdr0_dst = '0; ifdr0_we = 1'b0;
        ifdr0_taken = 1'b0;
        drex_valid = '0; drex_cls = '0; drex_dst = '0; drex_we = '0;
        drex_taken = '0;
        edf_valid = '0; edf_cls = '0; edf_dst = '0; edf_we = '0;
    endtask

    // Wait to a falling edge, then compare the four outputs
    task automatic expect4(input string tag, input logic e0, input logic e1,
                           input logic ec1, input logic ec);
        @(negedge clk);
        n_run++;
        if ({s0, s1, c1, c} !== {e0, e1, ec1, ec}) begin
            n_fail++;
            $display("FAIL %s: got s0/s1/c1/c=%b%b%b%b expected %b%b%b%b",
                     tag, s0, s1, c1, c, e0, e1, ec1, ec);
        end
    endtask

    // Reset state with nothing valid: all quiet (R10)
    task automatic t_reset();
        clr();
        expect4("R10 idle", 0, 0, 0, 0);
    endtask

    // Same-bundle read-after-write (R1)
    task automatic t_bundle_raw();
        clr();
        ifdr_valid = 2'b11;
        ifdr_cls[0] = CLS_ALU; ifdr0_dst = 5'd5; ifdr0_we = 1'b1;
        ifdr_cls[1] = CLS_ALU; ifdr_src_a[1] = 5'd5; ifdr_use_a[1] = 1'b1;
        expect4("R1 alu->alu", 0, 1, 0, 0);
        ifdr0_we = 1'b0;
        expect4("R1 no write enable", 0, 0, 0, 0);
        ifdr0_we = 1'b1; ifdr0_dst = 5'd0; ifdr_src_a[1] = 5'd0;
        expect4("R1 register zero", 0, 0, 0, 0);
        ifdr_cls[0] = CLS_LDI; ifdr0_dst = 5'd7; ifdr_use_a[1] = 1'b0;
        ifdr_cls[1] = CLS_JMPR; ifdr_src_b[1] = 5'd7; ifdr_use_b[1] = 1'b1;
        expect4("R1 ldi->jmpr src b", 0, 1, 0, 0);
        ifdr_cls[1] = CLS_JMP;
        expect4("R1 plain jmp not reader", 0, 0, 0, 0);
    endtask

    // Shared load/store pipe (R2)
    task automatic t_mem_pair();
        clr();
        ifdr_valid = 2'b11;
        ifdr_cls[0] = CLS_LD; ifdr_cls[1] = CLS_ST;
        expect4("R2 ld+st", 0, 1, 0, 0);
        ifdr_cls[1] = CLS_ALU;
        expect4("R2 ld+alu", 0, 0, 0, 0);
    endtask

    // Predicate writers in the bundle (R3)
    task automatic t_bundle_pred();
        clr();
        ifdr_valid = 2'b11;
        ifdr_cls[0] = CLS_CMP; ifdr_cls[1] = CLS_JMP;
        expect4("R3 cmp+jmp", 0, 1, 0, 0);
        ifdr_cls[0] = CLS_CHPR; ifdr_cls[1] = CLS_NOP;
        expect4("R3 chpr+any", 0, 1, 0, 0);
        ifdr_cls[0] = CLS_ALU; ifdr_cls[1] = CLS_JMP;
        expect4("R3 alu+jmp", 0, 0, 0, 0);
    endtask

    // Load/multiply in DR/E (R4)
    task automatic t_drex_long();
        clr();
        drex_valid[1] = 1'b1; drex_cls[1] = CLS_LD; drex_dst[1] = 5'd9;
        drex_we[1] = 1'b1;
        ifdr_valid = 2'b01; ifdr_cls[0] = CLS_ALU;
        ifdr_src_a[0] = 5'd9; ifdr_use_a[0] = 1'b1;
        expect4("R4 ld->slot0", 1, 0, 0, 0);
        ifdr_valid = 2'b11; ifdr_use_a[0] = 1'b0;
        ifdr_cls[1] = CLS_CMP; ifdr_src_b[1] = 5'd9; ifdr_use_b[1] = 1'b1;
        expect4("R4 ld->slot1", 0, 1, 0, 0);
        drex_cls[1] = CLS_ALU;
        expect4("R4 alu producer", 0, 0, 0, 0);
    endtask

    // Predicate writer in DR/E followed by predicate-set change (R5)
    task automatic t_drex_pred();
        clr();
        drex_valid[0] = 1'b1; drex_cls[0] = CLS_CMP;
        ifdr_valid = 2'b10; ifdr_cls[1] = CLS_CHPR;
        expect4("R5 cmp->slot1 chpr", 0, 1, 0, 0);
        ifdr_valid = 2'b01; ifdr_cls[0] = CLS_CHPR;
        expect4("R5 cmp->slot0 chpr", 1, 0, 0, 0);
    endtask

    // Multiplier in E/DF, read dependency (R6)
    task automatic t_edf_raw();
        clr();
        edf_valid[1] = 1'b1; edf_cls[1] = CLS_PMUL; edf_dst[1] = 5'd12;
        edf_we[1] = 1'b1;
        ifdr_valid = 2'b01; ifdr_cls[0] = CLS_CMP;
        ifdr_src_b[0] = 5'd12; ifdr_use_b[0] = 1'b1;
        expect4("R6 pmul->cmp", 1, 0, 0, 0);
        edf_cls[1] = CLS_LD;
        expect4("R6 ld in edf", 0, 0, 0, 0);
    endtask

    // Write-port collision (R7)
    task automatic t_port();
        clr();
        edf_valid[0] = 1'b1; edf_cls[0] = CLS_PMUL; edf_dst[0] = 5'd3;
        edf_we[0] = 1'b1;
        ifdr_valid = 2'b01; ifdr_cls[0] = CLS_ALU; ifdr0_dst = 5'd20;
        ifdr0_we = 1'b1;
        expect4("R7 alu writer", 1, 0, 0, 0);
        ifdr_cls[0] = CLS_PMUL;
        expect4("R7 pmul writer", 0, 0, 0, 0);
        ifdr_valid = 2'b10; ifdr_cls[1] = CLS_LDI;
        expect4("R7 slot1 only", 0, 0, 0, 0);
    endtask

    // Slot 0 taken jump (R8)
    task automatic t_jump0();
        clr();
        ifdr_valid = 2'b11; ifdr_cls[0] = CLS_JMP; ifdr0_taken = 1'b1;
        drex_valid[0] = 1'b1; drex_cls[0] = CLS_LD; drex_dst[0] = 5'd4;
        drex_we[0] = 1'b1;
        ifdr_cls[1] = CLS_ALU; ifdr_src_a[1] = 5'd4; ifdr_use_a[1] = 1'b1;
        expect4("R8 cancel over slot1 stall", 0, 0, 1, 0);
        ifdr_cls[0] = CLS_JMPR; ifdr_src_a[0] = 5'd4; ifdr_use_a[0] = 1'b1;
        expect4("R8 stalled jump no cancel", 1, 0, 0, 0);
        ifdr0_taken = 1'b0; ifdr_use_a[0] = 1'b0;
        expect4("R8 not taken", 0, 1, 0, 0);
    endtask

    // DR/E taken jump (R9)
    task automatic t_jump_dr();
        clr();
        drex_valid[1] = 1'b1; drex_cls[1] = CLS_JMP; drex_taken[1] = 1'b1;
        edf_valid[0] = 1'b1; edf_cls[0] = CLS_PMUL; edf_dst[0] = 5'd6;
        edf_we[0] = 1'b1;
        ifdr_valid = 2'b11; ifdr_cls[0] = CLS_JMP; ifdr0_taken = 1'b1;
        ifdr_cls[1] = CLS_ALU; ifdr_src_a[1] = 5'd6; ifdr_use_a[1] = 1'b1;
        expect4("R9 overrides all", 0, 0, 0, 1);
        drex_valid[1] = 1'b0;
        expect4("R9 invalid jump ignored", 0, 0, 1, 0);
    endtask

    // Priority and invalid producers (R10)
    task automatic t_prio();
        clr();
        drex_valid[0] = 1'b0; drex_cls[0] = CLS_LD; drex_dst[0] = 5'd8;
        drex_we[0] = 1'b1;
        ifdr_valid = 2'b01; ifdr_cls[0] = CLS_ALU;
        ifdr_src_a[0] = 5'd8; ifdr_use_a[0] = 1'b1;
        expect4("R10 invalid producer", 0, 0, 0, 0);
        drex_valid[0] = 1'b1; ifdr_valid = 2'b11;
        ifdr_cls[1] = CLS_ST; ifdr_cls[0] = CLS_LD;
        expect4("R10 slot0 over slot1", 1, 0, 0, 0);
    endtask

    initial begin
        clr();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bundle_raw();
        t_mem_pair();
        t_bundle_pred();
        t_drex_long();
        t_drex_pred();
        t_edf_raw();
        t_port();
        t_jump0();
        t_jump_dr();
        t_prio();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got running expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule